// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block builds one 32-bit output pixel per clock from three words that arrive together: an 8-bit colour index, a 32-bit direct-colour word and a 32-bit control-plane word. The most significant byte of the control word is a per-pixel tag. One tag value selects the direct colour for that pixel. Any other value sends the index to an external colour lookup table and uses the entry that comes back. The lookup table is read combinationally in the same cycle, so it stays outside the block.

The direct word keeps its components with blue in the highest of its three low bytes and red in the lowest. A static configuration input packs the chosen colour into the output word in either RGB order or BGR order. The top byte of the output is always zero. The stream has no handshake. A valid strobe travels beside the data, and the result appears exactly one clock later. Scan lines have a fixed length, and the block flags the pixel that closes each line.

Top module: `pxsel_color_select`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_last` and `out_pixel` are all zero.
- R2: A pixel whose control-word bits [31:24] equal 0x03 takes its colour from the direct word. Bits [23:0] of the control word do not affect the selection, so a word of 0x00000003 selects the lookup table.
- R3: A pixel with any other tag takes its colour from `pal_data`. The value on `pal_addr` equals `pix_idx` in the same cycle. `pal_data` holds red in [23:16], green in [15:8] and blue in [7:0].
- R4: In the direct word, red is in bits [7:0], green in [15:8] and blue in [23:16]. Bits [31:24] of the direct word are ignored.
- R5: With `cfg_bgr` low, the output holds red in [23:16], green in [15:8] and blue in [7:0]. With `cfg_bgr` high, blue is in [23:16] and red is in [7:0].
- R6: Bits [31:24] of `out_pixel` are always zero.
- R7: `out_valid` equals `in_valid` from the previous clock, and `out_pixel` carries the colour formed from the inputs of that clock.
- R8: When `in_valid` is low, `out_pixel` keeps its previous value.
- R9: `out_last` rises with the 1024th valid pixel after reset and with every 1024th valid pixel after that, and at no other time. Cycles without `in_valid` do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bgr | input | 1 | Output packing: 0 = RGB, 1 = BGR |
| in_valid | input | 1 | Input pixel strobe |
| pix_idx | input | 8 | Colour index |
| direct_word | input | 32 | Direct colour word |
| ctrl_word | input | 32 | Control-plane word; the tag is in [31:24] |
| pal_addr | output | 8 | Lookup-table address |
| pal_data | input | 24 | Lookup-table entry for `pal_addr` |
| out_valid | output | 1 | Output pixel strobe |
| out_pixel | output | 32 | Packed output pixel |
| out_last | output | 1 | Marks the final pixel of a scan line |

## Verification
Two things can happen on the same output beat: the line-end flag, and the per-pixel switch between direct colour and lookup. The bench fills a line with lookup pixels until exactly one slot is left. It then sends a direct-tagged pixel with BGR packing in that slot. On that beat it expects both the flag and the reordered direct colour, the beat before must show no flag, and the beat after must have the count restarted. A reset in the middle of a line is checked the same way: the count must restart from zero.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

   localparam int COMP_W = 8;

   typedef struct packed {
      logic [COMP_W-1:0] red;
      logic [COMP_W-1:0] green;
      logic [COMP_W-1:0] blue;
   } rgb_t;

   // pack a colour into a 4-component word, top component zero
   function automatic logic [4*COMP_W-1:0] pack_rgb(input rgb_t c, input logic bgr);
      logic [4*COMP_W-1:0] w;
      if (bgr) w = {{COMP_W{1'b0}}, c.blue, c.green, c.red};
      else     w = {{COMP_W{1'b0}}, c.red, c.green, c.blue};
      return w;
   endfunction

endpackage

// File: rtl/pxsel_mode_decode.sv
module pxsel_mode_decode #(
   parameter int WORD_W         = 32,
   parameter int TAG_W          = 8,
   parameter int DIRECT_TAG     = 3,
   parameter bit CTRL_LANE_SWAP = 1'b0
) (
   input  logic [WORD_W-1:0] ctrl_word,
   output logic              is_direct
);
   localparam logic [TAG_W-1:0] TAG_V = TAG_W'(DIRECT_TAG);

   logic [TAG_W-1:0] tag;
   logic             unused_low;

   generate
      if (TAG_W > WORD_W) begin : g_bad_tag
         $error("pxsel_mode_decode: tag wider than control word");
      end
      if (CTRL_LANE_SWAP) begin : g_swap
         // word arrives with byte lanes reversed: tag sits in the low lane
         assign tag        = ctrl_word[TAG_W-1:0];
         assign unused_low = ^ctrl_word[WORD_W-1:TAG_W];
      end else begin : g_native
         assign tag        = ctrl_word[WORD_W-1 -: TAG_W];
         assign unused_low = ^ctrl_word[WORD_W-TAG_W-1:0];
      end
   endgenerate

   assign is_direct = (tag == TAG_V);

endmodule

// File: rtl/pxsel_color_order.sv
module pxsel_color_order
   import pxsel_pkg::*;
#(
   parameter bit DIRECT_BGR = 1'b1
) (
   input  logic               is_direct,
   input  logic [4*COMP_W-1:0] direct_word,
   input  logic [3*COMP_W-1:0] pal_data,
   input  logic               cfg_bgr,
   output logic [4*COMP_W-1:0] pixel
);
   rgb_t dir_c;
   rgb_t pal_c;
   rgb_t sel_c;
   logic unused_hi;

   assign unused_hi = ^direct_word[4*COMP_W-1:3*COMP_W];

   generate
      if (DIRECT_BGR) begin : g_dir_bgr
         assign dir_c.red   = direct_word[COMP_W-1:0];
         assign dir_c.green = direct_word[2*COMP_W-1:COMP_W];
         assign dir_c.blue  = direct_word[3*COMP_W-1:2*COMP_W];
      end else begin : g_dir_rgb
         assign dir_c.blue  = direct_word[COMP_W-1:0];
         assign dir_c.green = direct_word[2*COMP_W-1:COMP_W];
         assign dir_c.red   = direct_word[3*COMP_W-1:2*COMP_W];
      end
   endgenerate

   assign pal_c = rgb_t'(pal_data);

   always_comb begin
      sel_c = is_direct ? dir_c : pal_c;
      pixel = pack_rgb(sel_c, cfg_bgr);
   end

endmodule

// File: rtl/pxsel_line_track.sv
module pxsel_line_track #(
   parameter int LINE_PIXELS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   output logic in_last
);
   localparam int LINE_W = (LINE_PIXELS > 1) ? $clog2(LINE_PIXELS) : 1;
   localparam logic [LINE_W-1:0] LAST_POS = LINE_W'(LINE_PIXELS - 1);

   logic [LINE_W-1:0] pos_q;

   generate
      if (LINE_PIXELS < 2) begin : g_bad_line
         $error("pxsel_line_track: LINE_PIXELS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (in_valid) begin
         pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      end
   end

   assign in_last = in_valid && (pos_q == LAST_POS);

   // position only moves on a valid pixel
   AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(pos_q)) else $error("position moved without pixel"); // R9

   // after a line end the count is back at zero
   AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      in_last |=> (pos_q == '0)) else $error("line count did not wrap"); // R9

endmodule

// File: rtl/pxsel_out_reg.sv
module pxsel_out_reg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic [WORD_W-1:0] pix_d,
   output logic              out_valid,
   output logic              out_last,
   output logic [WORD_W-1:0] out_pixel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_pixel <= '0;
      end else begin
         out_valid <= in_valid;
         out_last  <= in_last;
         if (in_valid) out_pixel <= pix_d;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("valid lost"); // R7

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid) else $error("valid without input"); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_pixel)) else $error("pixel changed while idle"); // R8

   AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid) else $error("line end without pixel"); // R9

endmodule

// File: rtl/pxsel_color_select.sv
module pxsel_color_select
   import pxsel_pkg::*;
#(
   parameter int PIX_W          = 8,
   parameter int LINE_PIXELS    = 1024,
   parameter int DIRECT_TAG     = 3,
   parameter bit DIRECT_BGR     = 1'b1,
   parameter bit CTRL_LANE_SWAP = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_bgr,
   input  logic                in_valid,
   input  logic [PIX_W-1:0]    pix_idx,
   input  logic [4*COMP_W-1:0] direct_word,
   input  logic [4*COMP_W-1:0] ctrl_word,
   output logic [PIX_W-1:0]    pal_addr,
   input  logic [3*COMP_W-1:0] pal_data,
   output logic                out_valid,
   output logic [4*COMP_W-1:0] out_pixel,
   output logic                out_last
);
   localparam int WORD_W = 4 * COMP_W;

   logic              is_direct;
   logic              in_last;
   logic [WORD_W-1:0] pix_d;

   generate
      if (PIX_W < 1 || PIX_W > 16) begin : g_bad_pix
         $error("pxsel_color_select: PIX_W out of range");
      end
      if (DIRECT_TAG < 0 || DIRECT_TAG >= (1 << COMP_W)) begin : g_bad_tag
         $error("pxsel_color_select: DIRECT_TAG does not fit a tag byte");
      end
   endgenerate

   assign pal_addr = pix_idx;

   pxsel_mode_decode #(
      .WORD_W(WORD_W), .TAG_W(COMP_W),
      .DIRECT_TAG(DIRECT_TAG), .CTRL_LANE_SWAP(CTRL_LANE_SWAP)
   ) u_decode (
      .ctrl_word(ctrl_word),
      .is_direct(is_direct)
   );

   pxsel_color_order #(.DIRECT_BGR(DIRECT_BGR)) u_order (
      .is_direct(is_direct),
      .direct_word(direct_word),
      .pal_data(pal_data),
      .cfg_bgr(cfg_bgr),
      .pixel(pix_d)
   );

   pxsel_line_track #(.LINE_PIXELS(LINE_PIXELS)) u_line (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid),
      .in_last(in_last)
   );

   pxsel_out_reg #(.WORD_W(WORD_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_last(in_last), .pix_d(pix_d),
      .out_valid(out_valid), .out_last(out_last), .out_pixel(out_pixel)
   );

   AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_pixel[WORD_W-1 -: COMP_W] == '0) else $error("top byte set"); // R6

   AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      pal_addr == pix_idx) else $error("lookup address mismatch"); // R3

   AST_LOOKUP_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_direct && !cfg_bgr) |=> out_pixel[3*COMP_W-1:0] == $past(pal_data))
      else $error("lookup colour lost"); // R3

   AST_DIRECT_RED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_direct && cfg_bgr && DIRECT_BGR) |=>
         out_pixel[COMP_W-1:0] == $past(direct_word[COMP_W-1:0]))
      else $error("direct red misplaced"); // R4

endmodule

// File: tb/tb_pxsel_color_select.sv
module tb_pxsel_color_select;
   localparam int CLK_PERIOD = 10;
   localparam int LINE = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bgr = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  pix_idx = '0;
   logic [31:0] direct_word = '0;
   logic [31:0] ctrl_word = '0;
   logic [7:0]  pal_addr;
   logic [23:0] pal_data;
   logic        out_valid;
   logic [31:0] out_pixel;
   logic        out_last;

   int total = 0;
   int bad = 0;
   int sent = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // external lookup table model
   assign pal_data = {~pal_addr, pal_addr ^ 8'h5A, pal_addr + 8'd7};

   pxsel_color_select dut (
      .clk(clk), .rst_n(rst_n), .cfg_bgr(cfg_bgr), .in_valid(in_valid),
      .pix_idx(pix_idx), .direct_word(direct_word), .ctrl_word(ctrl_word),
      .pal_addr(pal_addr), .pal_data(pal_data),
      .out_valid(out_valid), .out_pixel(out_pixel), .out_last(out_last)
   );

   function automatic logic [31:0] model(input logic [7:0] idx, input logic [31:0] dw,
                                         input logic [31:0] cw, input logic bgr);
      logic [7:0] r, g, b;
      if (cw[31:24] == 8'h03) begin
         r = dw[7:0]; g = dw[15:8]; b = dw[23:16];
      end else begin
         r = ~idx; g = idx ^ 8'h5A; b = idx + 8'd7;
      end
      return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one cycle at the falling edge; outputs settle just after the next rising edge
   task automatic drive(input logic v, input logic [7:0] idx, input logic [31:0] dw,
                        input logic [31:0] cw);
      @(negedge clk);
      in_valid = v; pix_idx = idx; direct_word = dw; ctrl_word = cw;
      @(posedge clk);
      #1;
      if (v) sent++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      #1;
      chk(out_valid == 1'b0 && out_last == 1'b0, "R1 flags", {30'b0, out_valid, out_last}, 32'h0);
      chk(out_pixel == 32'h0, "R1 pixel", out_pixel, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      sent = 0;
   endtask

   task automatic t_direct();
      logic [31:0] e;
      cfg_bgr = 1'b0;
      drive(1'b1, 8'h11, 32'hEE_332211, 32'h03_000000);
      e = model(8'h11, 32'hEE332211, 32'h03000000, 1'b0);
      chk(out_pixel == e && e == 32'h00112233, "R2 R4 direct rgb", out_pixel, 32'h00112233);
      chk(out_valid == 1'b1, "R7 valid after one clock", {31'b0, out_valid}, 32'h1);
      cfg_bgr = 1'b1;
      drive(1'b1, 8'h11, 32'h77_C0B0A0, 32'h03_FFFFFF);
      chk(out_pixel == 32'h00C0B0A0, "R5 R4 direct bgr", out_pixel, 32'h00C0B0A0);
      chk(out_pixel[31:24] == 8'h00, "R6 top byte", out_pixel, 32'h00C0B0A0);
   endtask

   task automatic t_lookup();
      logic [31:0] e;
      logic [7:0] tags [5] = '{8'h00, 8'h02, 8'h04, 8'hFF, 8'h83};
      cfg_bgr = 1'b0;
      foreach (tags[i]) begin
         drive(1'b1, 8'(8'h20 + i * 8'h31), 32'hFFFFFFFF, {tags[i], 24'h030303});
         e = model(8'(8'h20 + i * 8'h31), 32'hFFFFFFFF, {tags[i], 24'h030303}, 1'b0);
         chk(out_pixel == e, "R3 lookup for non-direct tag", out_pixel, e);
      end
      drive(1'b1, 8'h9C, 32'h00ABCDEF, 32'h00000003);
      e = model(8'h9C, 32'h00ABCDEF, 32'h00000003, 1'b0);
      chk(out_pixel == e, "R2 low control bits ignored", out_pixel, e);
      cfg_bgr = 1'b1;
      drive(1'b1, 8'h40, 32'h0, 32'h01000000);
      e = model(8'h40, 32'h0, 32'h01000000, 1'b1);
      chk(out_pixel == e, "R5 lookup bgr", out_pixel, e);
   endtask

   task automatic t_idle_hold();
      logic [31:0] prev;
      cfg_bgr = 1'b0;
      drive(1'b1, 8'h05, 32'h00123456, 32'h03000000);
      prev = out_pixel;
      drive(1'b0, 8'hAA, 32'h00FFFFFF, 32'h03000000);
      chk(out_valid == 1'b0, "R7 valid drops", {31'b0, out_valid}, 32'h0);
      chk(out_pixel == prev, "R8 hold while idle", out_pixel, prev);
      drive(1'b0, 8'h55, 32'h0, 32'h0);
      chk(out_pixel == prev, "R8 hold second idle", out_pixel, prev);
   endtask

   task automatic t_line_end();
      logic [31:0] e;
      int miss = 0;
      cfg_bgr = 1'b0;
      while ((sent % LINE) != LINE - 2) begin
         drive(1'b1, 8'(sent), 32'h0, 32'h0);
         if (out_last) miss++;
         if ((sent % 7) == 0) drive(1'b0, 8'h0, 32'h0, 32'h0);
      end
      chk(miss == 0, "R9 no early line end", miss, 0);
      drive(1'b1, 8'h33, 32'h0, 32'h0);
      chk(out_last == 1'b0, "R9 not on pixel 1023", {31'b0, out_last}, 32'h0);
      cfg_bgr = 1'b1;
      drive(1'b1, 8'h00, 32'h00654321, 32'h03000000);
      e = model(8'h00, 32'h00654321, 32'h03000000, 1'b1);
      chk(out_last == 1'b1, "R9 line end on pixel 1024", {31'b0, out_last}, 32'h1);
      chk(out_pixel == e, "R5 R2 direct bgr on line end", out_pixel, e);
      drive(1'b1, 8'h01, 32'h0, 32'h0);
      chk(out_last == 1'b0, "R9 count restarts", {31'b0, out_last}, 32'h0);
   endtask

   task automatic t_reset_midline();
      for (int i = 0; i < 500; i++) drive(1'b1, 8'(i), 32'h0, 32'h0);
      do_reset();
      while (sent < LINE - 1) drive(1'b1, 8'h0, 32'h0, 32'h0);
      chk(out_last == 1'b0, "R9 reset clears position", {31'b0, out_last}, 32'h0);
      drive(1'b1, 8'h0, 32'h0, 32'h0);
      chk(out_last == 1'b1, "R9 line end after reset", {31'b0, out_last}, 32'h1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      do_reset();
      t_direct();
      t_lookup();
      t_idle_hold();
      t_line_end();
      t_reset_midline();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule